// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the control pins of an SDRAM device on every rising clock edge and turns them into decoded commands. It keeps a record of which of the four banks hold an open row and which row that is. It also flags command sequences that break the bank state rules. The decode result, the bank or banks that a command touches and a one-cycle error flag are registered and appear after the edge that sampled the pins.

The block follows the clock enable pin in two ways. A low clock enable freezes the tracker for the following edge. A refresh command given with clock enable low enters self-refresh, and the block leaves it once clock enable is sampled high again. Reads and writes issued with A10 high arm a per-bank countdown that closes the bank when the burst ends. An internal refresh row counter advances on each accepted auto-refresh.

A controller or protocol monitor can use it to track bank state, or as a checker that sits beside a memory interface.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: After reset, `cmd_out` is NOP (0), `bank_hit`, `err`, `bank_open` and `ref_row` are zero, and `in_sref` is low.
- R2: With chip select low, the pins (ras_n, cas_n, we_n) decode as follows: L,H,H is ACT (code 1); H,L,H is READ (2); H,L,L is WRITE (3); L,H,L is PRE (4), or PREALL (5) when A10 is high; L,L,H is AREF (6) when CKE is high, or SREF (7) when CKE is low. Every other pattern is NOP (0). `bank_hit` is one-hot at bit `ba` for ACT, READ, WRITE and PRE, and 4'b1111 for PREALL, AREF and SREF.
- R3: An accepted ACT sets `bank_open[ba]` and stores the address in `open_rows[ba*12 +: 12]`.
- R4: PRE closes bank `ba`. PREALL (PRE with A10 high) closes every bank.
- R5: A READ or WRITE with A10 high closes its bank at the BURST-th accepted edge after the command. With BURST=4, the bank still reads open after the third following edge and reads closed after the fourth.
- R6: A PRE to a bank that has an auto-close pending closes the bank at once and cancels the countdown.
- R7: ACT to an open bank, READ or WRITE to a closed bank, and any refresh while a bank is open raise `err` for one cycle and change no bank, row or counter state.
- R8: When CKE is sampled low at an edge, the command sampled at the next edge is ignored (`cmd_out` NOP, no state change).
- R9: An accepted SREF sets `in_sref`. While it is set, commands are ignored. The edge that samples CKE high clears `in_sref` and is itself ignored. The edge after that accepts commands.
- R10: Each AREF without error adds one to `ref_row`, which wraps after 4096 rows. Chip select high forces NOP and leaves all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| a10 | input | 1 | Precharge option bit |
| ba | input | 2 | Bank address |
| addr | input | 12 | Row address (column uses low 9 bits) |
| cmd_out | output | 3 | Decoded command code |
| bank_hit | output | 4 | Banks affected by the command |
| err | output | 1 | Illegal sequence pulse |
| bank_open | output | 4 | Per-bank open flag |
| open_rows | output | 48 | Open row per bank, 12 bits each |
| in_sref | output | 1 | Self-refresh active |
| ref_row | output | 12 | Internal refresh row counter |

## Verification
A vector table walks one sequence that starts with all banks idle. It opens banks, repeats an ACT, reads an idle bank, deselects, refreshes while rows are open, then precharges one bank and then all. This separates the legal commands from the illegal ones and the single-bank close from the all-bank close. Directed tests then vary only the timing inputs. CKE low against CKE high on an identical ACT shows that the frozen edge is ignored. A10 high with no PRE is compared against A10 high followed by PRE to confirm the countdown and its cancellation. A refresh with CKE low against one with CKE high separates self-refresh from auto-refresh. A run of 4096 auto-refreshes shows the row counter wrapping.

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker #(
  parameter int ROW_W = 12,
  parameter int BA_W  = 2,
  parameter int BURST = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cs_n,
  input  logic                        ras_n,
  input  logic                        cas_n,
  input  logic                        we_n,
  input  logic                        cke,
  input  logic                        a10,
  input  logic [BA_W-1:0]             ba,
  input  logic [ROW_W-1:0]            addr,
  output logic [2:0]                  cmd_out,
  output logic [(1<<BA_W)-1:0]        bank_hit,
  output logic                        err,
  output logic [(1<<BA_W)-1:0]        bank_open,
  output logic [(1<<BA_W)*ROW_W-1:0]  open_rows,
  output logic                        in_sref,
  output logic [ROW_W-1:0]            ref_row
);
  localparam int NB = 1 << BA_W;
  localparam int CW = $clog2(BURST + 1);
  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                         C_PRE = 3'd4, C_PALL = 3'd5, C_AREF = 3'd6, C_SREF = 3'd7;

  logic              cke_q;
  logic [ROW_W-1:0]  rows [NB];
  logic [CW-1:0]     apc  [NB];

  wire tick   = cke_q & ~in_sref;
  wire sel    = ~cs_n;
  wire is_act = sel & ~ras_n &  cas_n &  we_n;
  wire is_rd  = sel &  ras_n & ~cas_n &  we_n;
  wire is_wr  = sel &  ras_n & ~cas_n & ~we_n;
  wire is_pre = sel & ~ras_n &  cas_n & ~we_n;
  wire is_ref = sel & ~ras_n & ~cas_n &  we_n;
  wire [NB-1:0] bmask = NB'(1) << ba;
  wire bad = (is_act & bank_open[ba]) | ((is_rd | is_wr) & ~bank_open[ba])
           | (is_ref & (|bank_open));

  for (genvar b = 0; b < NB; b++) begin : g_rows
    assign open_rows[b*ROW_W +: ROW_W] = rows[b];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cke_q     <= 1'b1;
      in_sref   <= 1'b0;
      cmd_out   <= C_NOP;
      bank_hit  <= '0;
      err       <= 1'b0;
      bank_open <= '0;
      ref_row   <= '0;
      for (int b = 0; b < NB; b++) begin
        rows[b] <= '0;
        apc[b]  <= '0;
      end
    end else begin
      cke_q    <= cke;
      cmd_out  <= C_NOP;
      bank_hit <= '0;
      err      <= 1'b0;
      if (in_sref) begin
        if (cke) in_sref <= 1'b0;
      end else if (tick) begin
        for (int b = 0; b < NB; b++) begin
          if (apc[b] > CW'(1)) apc[b] <= apc[b] - CW'(1);
          else if (apc[b] == CW'(1)) begin
            apc[b]       <= '0;
            bank_open[b] <= 1'b0;
          end
        end
        err <= bad;
        if (is_act) begin
          cmd_out  <= C_ACT;
          bank_hit <= bmask;
          if (!bad) begin
            bank_open[ba] <= 1'b1;
            rows[ba]      <= addr;
            apc[ba]       <= '0;
          end
        end else if (is_rd | is_wr) begin
          cmd_out  <= is_rd ? C_RD : C_WR;
          bank_hit <= bmask;
          if (!bad) apc[ba] <= a10 ? CW'(BURST) : '0;
        end else if (is_pre) begin
          cmd_out  <= a10 ? C_PALL : C_PRE;
          bank_hit <= a10 ? '1 : bmask;
          for (int b = 0; b < NB; b++) begin
            if (a10 || BA_W'(b) == ba) begin
              bank_open[b] <= 1'b0;
              apc[b]       <= '0;
            end
          end
        end else if (is_ref) begin
          cmd_out  <= cke ? C_AREF : C_SREF;
          bank_hit <= '1;
          if (!bad) begin
            if (cke) ref_row <= ref_row + ROW_W'(1);
            else     in_sref <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk #(
  parameter int ROW_W = 12,
  parameter int NB    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       cmd_out,
  input logic [NB-1:0]    bank_hit,
  input logic             err,
  input logic [NB-1:0]    bank_open,
  input logic             in_sref,
  input logic [ROW_W-1:0] ref_row
);
  assert_err_has_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> cmd_out != 3'd0);
  assert_single_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_out inside {3'd1, 3'd2, 3'd3, 3'd4}) |-> $onehot(bank_hit));
  assert_act_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_out == 3'd1 && !err) |-> (bank_open & bank_hit) != '0);
  assert_prall_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_out == 3'd5 |-> bank_open == '0);
  assert_sref_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_sref |=> cmd_out == 3'd0);
  assert_ref_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_out == 3'd6 && !err) |-> ref_row == $past(ref_row) + ROW_W'(1));
endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(.ROW_W(ROW_W), .NB(1 << BA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_out(cmd_out), .bank_hit(bank_hit), .err(err),
  .bank_open(bank_open), .in_sref(in_sref), .ref_row(ref_row));

// File: tb/sdram_cmd_tracker_test.sv
`timescale 1ns/1ps
module sdram_cmd_tracker_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1, a10 = 1'b0;
  logic [1:0]  ba = '0;
  logic [11:0] addr = '0;
  logic [2:0]  cmd_out;
  logic [3:0]  bank_hit, bank_open;
  logic        err, in_sref;
  logic [47:0] open_rows;
  logic [11:0] ref_row;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  sdram_cmd_tracker uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cke(cke), .a10(a10), .ba(ba), .addr(addr), .cmd_out(cmd_out), .bank_hit(bank_hit),
    .err(err), .bank_open(bank_open), .open_rows(open_rows), .in_sref(in_sref),
    .ref_row(ref_row));

  // {cs,ras,cas,we,a10, ba, addr, cmd, hit, err, open}
  localparam logic [30:0] VEC [11] = '{
    {5'b00110, 2'd0, 12'h123, 3'd1, 4'b0001, 1'b0, 4'b0001},
    {5'b00110, 2'd0, 12'h456, 3'd1, 4'b0001, 1'b1, 4'b0001},
    {5'b01010, 2'd1, 12'h000, 3'd2, 4'b0010, 1'b1, 4'b0001},
    {5'b00110, 2'd2, 12'hABC, 3'd1, 4'b0100, 1'b0, 4'b0101},
    {5'b01000, 2'd2, 12'h000, 3'd3, 4'b0100, 1'b0, 4'b0101},
    {5'b10110, 2'd3, 12'h000, 3'd0, 4'b0000, 1'b0, 4'b0101},
    {5'b00010, 2'd0, 12'h000, 3'd6, 4'b1111, 1'b1, 4'b0101},
    {5'b00100, 2'd0, 12'h000, 3'd4, 4'b0001, 1'b0, 4'b0100},
    {5'b00101, 2'd1, 12'h000, 3'd5, 4'b1111, 1'b0, 4'b0000},
    {5'b00010, 2'd0, 12'h000, 3'd6, 4'b1111, 1'b0, 4'b0000},
    {5'b01110, 2'd0, 12'h000, 3'd0, 4'b0000, 1'b0, 4'b0000}
  };

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] c, input logic k, input logic [1:0] b, input logic [11:0] a);
    {cs_n, ras_n, cas_n, we_n, a10} = c;
    cke = k; ba = b; addr = a;
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  initial begin
    #600000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) step();
    chk("R1 cmd", cmd_out, 0);
    chk("R1 open", bank_open, 0);
    chk("R1 ref_row", ref_row, 0);
    chk("R1 sref", in_sref, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 11; i++) begin
      drive(VEC[i][30:26], 1'b1, VEC[i][25:24], VEC[i][23:12]);
      step();
      chk($sformatf("R2 cmd v%0d", i), cmd_out, VEC[i][11:9]);
      chk($sformatf("R2 hit v%0d", i), bank_hit, VEC[i][8:5]);
      chk($sformatf("R7 err v%0d", i), err, VEC[i][4]);
      chk($sformatf("R4 open v%0d", i), bank_open, VEC[i][3:0]);
      if (i == 1) chk("R3 R7 row0 kept", open_rows[11:0], 12'h123);
      if (i == 3) chk("R3 row2", open_rows[35:24], 12'hABC);
      if (i == 6) chk("R7 ref_row unchanged", ref_row, 0);
    end
    chk("R10 ref_row after one AREF", ref_row, 1);

    // R5 auto-close after BURST edges
    drive(5'b00110, 1'b1, 2'd3, 12'h777); step();
    drive(5'b01011, 1'b1, 2'd3, 12'h010); step();
    chk("R5 read cmd", cmd_out, 2);
    drive(5'b01110, 1'b1, 2'd0, 12'h000);
    for (int n = 1; n <= 3; n++) begin
      step();
      chk($sformatf("R5 open after %0d", n), bank_open[3], 1);
    end
    step();
    chk("R5 closed after 4", bank_open[3], 0);

    // R6 PRE cancels pending auto-close
    drive(5'b00110, 1'b1, 2'd3, 12'h001); step();
    drive(5'b01001, 1'b1, 2'd3, 12'h000); step();
    drive(5'b00100, 1'b1, 2'd3, 12'h000); step();
    chk("R6 pre closes", bank_open[3], 0);
    drive(5'b00110, 1'b1, 2'd3, 12'h002); step();
    chk("R6 reopen no err", err, 0);
    drive(5'b01110, 1'b1, 2'd0, 12'h000);
    repeat (4) step();
    chk("R6 countdown cancelled", bank_open[3], 1);
    drive(5'b00101, 1'b1, 2'd0, 12'h000); step();

    // R8 clock suspend
    drive(5'b01110, 1'b0, 2'd0, 12'h000); step();
    drive(5'b00110, 1'b1, 2'd1, 12'h055); step();
    chk("R8 suspended cmd", cmd_out, 0);
    chk("R8 suspended open", bank_open, 0);
    step();
    chk("R8 resumed cmd", cmd_out, 1);
    chk("R8 resumed open", bank_open, 4'b0010);
    drive(5'b00101, 1'b1, 2'd0, 12'h000); step();

    // R9 self-refresh
    drive(5'b00010, 1'b0, 2'd0, 12'h000); step();
    chk("R9 sref cmd", cmd_out, 7);
    chk("R9 in_sref", in_sref, 1);
    chk("R10 sref no count", ref_row, 1);
    drive(5'b00110, 1'b0, 2'd0, 12'h099);
    repeat (3) step();
    chk("R9 ignored open", bank_open, 0);
    chk("R9 still sref", in_sref, 1);
    cke = 1'b1; step();
    chk("R9 exit", in_sref, 0);
    chk("R9 exit edge ignored", cmd_out, 0);
    step();
    chk("R9 accepted after exit", cmd_out, 1);
    drive(5'b00101, 1'b1, 2'd0, 12'h000); step();

    // R10 wrap
    drive(5'b00010, 1'b1, 2'd0, 12'h000);
    repeat (4096) step();
    chk("R10 wrap", ref_row, 1);
    drive(5'b10000, 1'b1, 2'd0, 12'h000); step();
    chk("R10 deselect cmd", cmd_out, 0);
    chk("R10 deselect ref_row", ref_row, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule